// File: doc/BRIEF.md
# Dual-Mode Register Configuration Port

This block is the configuration front end of a three-channel analogue acquisition chip. It holds a small register file: one control byte, a 5-bit gain code for each channel, and a 9-bit sign-magnitude offset code for each channel. The three channel count, the field widths and the register base addresses are parameters.

Software reaches the registers through three shared pins. A static mode input decides what those pins mean. In serial mode they carry a data bit, a shift clock and an active-low word enable. In parallel mode they carry a data/address select, a read/write select and an active-low strobe, and each access moves one byte on an 8-bit configuration bus. A parallel read puts the selected register on an 8-bit slice of the sample output bus, together with an enable for the pad drivers.

All pins are asynchronous to the block clock. They pass through synchronisers and edge detectors, so every pin event acts at most three clock edges after it happens. The pins must therefore be held for several clocks per phase.

Top module: `cfg_port_top`

## Requirements
- R1: While the active-low reset is asserted, and immediately after it, every register reads zero, `sliceOe` is 0 and `sliceData` is 0.
- R2: `parMode`=1 selects the parallel meaning of the shared pins and `parMode`=0 selects the serial meaning. Pin activity in the unselected meaning changes no register and drives no readback. In particular, holding pin B high in serial mode leaves `sliceOe` at 0.
- R3: In serial mode, a bit is sampled from pin A on each rising edge of pin B while pin C is low. A falling edge on pin C starts a new word. The word is 16 bits, sent MSB first: the address in bits 15..8, then the data in bits 7..0. It is written into the register file on the rising edge of pin C.
- R4: A serial word with any bit count other than 16, whether fewer or more, is discarded at the rising edge of pin C, and no register changes.
- R5: In parallel mode, a rising edge of the strobe (pin C) with pin A low latches `cfgBus` as the current address.
- R6: In parallel mode, a rising edge of the strobe with pin A high and pin B low writes `cfgBus` into the register at the latched address.
- R7: In parallel mode, while pin B is high, `sliceOe` is 1 and `sliceData` carries the register at the latched address. Within three clocks of pin B going low, `sliceOe` returns to 0 and `sliceData` returns to 0.
- R8: The register map is as follows. The control byte is at 0x00 and holds all 8 bits. The channel gains are at 0x01..0x03 and keep bits 4..0; their upper bits read 0. The offset magnitudes are at 0x04..0x06 and hold 8 bits. The offset signs are at 0x07..0x09 and keep bit 0 only.
- R9: A write to any address outside 0x00..0x09 changes no register, and a read from such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low reset |
| parMode | input | 1 | 1 = parallel access, 0 = serial access |
| sharePinA | input | 1 | Serial data bit / parallel data-not-address select |
| sharePinB | input | 1 | Serial shift clock / parallel read-not-write |
| sharePinC | input | 1 | Serial word enable (low during a word) / parallel strobe (active low) |
| cfgBus | input | 8 | Parallel address or data byte |
| sliceData | output | 8 | Readback byte for bits 9..2 of the sample output bus |
| sliceOe | output | 1 | Drive enable for the readback slice (0 = high impedance) |

## Verification
The bench builds the block with its default parameters: three channels, 8-bit address and data, 5-bit gains and a two-stage synchroniser. With these values the whole register map fits inside the 0x00..0x0F range that the random addresses cover. Random traffic therefore hits, in mixed order, every mapped register, the masking of the gain and sign fields, and a band of unmapped addresses. Directed cases add short and long serial words, a readback attempt in serial mode, and switching between the two modes with registers holding data.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  typedef struct packed {
    logic serShift;   // rising shift clock inside a word
    logic serBit;     // synchronised serial data bit
    logic serClear;   // start of a serial word
    logic serCommit;  // end of a serial word
    logic parAddr;    // parallel address cycle completed
    logic parWrite;   // parallel data write completed
    logic readEn;     // parallel readback requested
  } cfgStrobes_t;
endpackage

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
  import cfg_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        parMode,
  input  logic        pinA,
  input  logic        pinB,
  input  logic        pinC,
  output cfgStrobes_t strobes
);
  // Idle level of the pins: enable/strobe high, others low.
  localparam logic [2:0] PIN_IDLE = 3'b100;

  logic [SYNC_STAGES-1:0][2:0] syncPipe;
  logic [2:0] syncPins;
  logic prevB, prevC;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncPipe <= {SYNC_STAGES{PIN_IDLE}};
      prevB    <= 1'b0;
      prevC    <= 1'b1;
    end else begin
      syncPipe <= {syncPipe[SYNC_STAGES-2:0], {pinC, pinB, pinA}};
      prevB    <= syncPins[1];
      prevC    <= syncPins[2];
    end
  end

  assign syncPins = syncPipe[SYNC_STAGES-1];

  logic riseB, riseC, fallC;
  assign riseB = syncPins[1] & ~prevB;
  assign riseC = syncPins[2] & ~prevC;
  assign fallC = ~syncPins[2] & prevC;

  always_comb begin
    strobes.serShift  = ~parMode & ~syncPins[2] & riseB;
    strobes.serBit    = syncPins[0];
    strobes.serClear  = ~parMode & fallC;
    strobes.serCommit = ~parMode & riseC;
    strobes.parAddr   = parMode & riseC & ~syncPins[0];
    strobes.parWrite  = parMode & riseC & syncPins[0] & ~syncPins[1];
    strobes.readEn    = parMode & syncPins[1];
  end

  // R2: the two access modes never fire strobes in the same cycle
  assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.serShift, strobes.serCommit, strobes.parAddr, strobes.parWrite}));
endmodule

// File: rtl/cfg_port_regs.sv
module cfg_port_regs
  import cfg_port_pkg::*;
#(
  parameter int NUM_CH     = 3,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int GAIN_W     = 5,
  parameter int CTRL_ADDR  = 0,
  parameter int GAIN_BASE  = 1,
  parameter int OFFLO_BASE = 4,
  parameter int OFFHI_BASE = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobes_t       strobes,
  input  logic [DATA_W-1:0] cfgBus,
  output logic [DATA_W-1:0] sliceData
);
  localparam int SER_BITS = ADDR_W + DATA_W;
  localparam int CNT_W    = $clog2(SER_BITS + 2);
  localparam int SNAP_W   = DATA_W + NUM_CH * (GAIN_W + DATA_W + 1);

  logic [DATA_W-1:0]   ctrlReg;
  logic [GAIN_W-1:0]   gainReg [NUM_CH];
  logic [DATA_W-1:0]   offMag  [NUM_CH];
  logic                offSign [NUM_CH];
  logic [ADDR_W-1:0]   addrReg;
  logic [SER_BITS-1:0] shiftReg;
  logic [CNT_W-1:0]    bitCnt;

  logic              wrEn;
  logic [ADDR_W-1:0] wrAddr;
  logic [DATA_W-1:0] wrData;

  assign wrEn   = strobes.parWrite | (strobes.serCommit && bitCnt == CNT_W'(SER_BITS));
  assign wrAddr = strobes.parWrite ? addrReg : shiftReg[SER_BITS-1 -: ADDR_W];
  assign wrData = strobes.parWrite ? cfgBus  : shiftReg[DATA_W-1:0];

  // Serial shifter and bit counter (saturates one past a full word).
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else begin
      if (strobes.serShift) shiftReg <= {shiftReg[SER_BITS-2:0], strobes.serBit};
      if (strobes.serClear)
        bitCnt <= strobes.serShift ? CNT_W'(1) : '0;
      else if (strobes.serShift && bitCnt <= CNT_W'(SER_BITS))
        bitCnt <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      ctrlReg <= '0;
    end else begin
      if (strobes.parAddr) addrReg <= cfgBus;
      if (wrEn && wrAddr == ADDR_W'(CTRL_ADDR)) ctrlReg <= wrData;
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        gainReg[ch] <= '0;
        offMag[ch]  <= '0;
        offSign[ch] <= 1'b0;
      end else if (wrEn) begin
        if (wrAddr == ADDR_W'(GAIN_BASE + ch))  gainReg[ch] <= wrData[GAIN_W-1:0];
        if (wrAddr == ADDR_W'(OFFLO_BASE + ch)) offMag[ch]  <= wrData;
        if (wrAddr == ADDR_W'(OFFHI_BASE + ch)) offSign[ch] <= wrData[0];
      end
    end
  end

  logic [DATA_W-1:0] readByte;
  always_comb begin
    readByte = '0;
    if (addrReg == ADDR_W'(CTRL_ADDR)) readByte = ctrlReg;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (addrReg == ADDR_W'(GAIN_BASE + ch))  readByte = DATA_W'(gainReg[ch]);
      if (addrReg == ADDR_W'(OFFLO_BASE + ch)) readByte = offMag[ch];
      if (addrReg == ADDR_W'(OFFHI_BASE + ch)) readByte = DATA_W'(offSign[ch]);
    end
  end

  assign sliceData = strobes.readEn ? readByte : '0;

  logic [SNAP_W-1:0] regSnapshot;
  always_comb begin
    regSnapshot = SNAP_W'(ctrlReg);
    for (int ch = 0; ch < NUM_CH; ch++)
      regSnapshot = {regSnapshot[SNAP_W-GAIN_W-DATA_W-2:0], gainReg[ch], offMag[ch], offSign[ch]};
  end

  // R4: a word of the wrong length leaves the register file untouched
  assert_short_word_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.serCommit && bitCnt != CNT_W'(SER_BITS)) |=> $stable(regSnapshot));
  // R2: without a commit or a parallel write, no register moves
  assert_quiet_regs_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.parWrite || strobes.serCommit) |=> $stable(regSnapshot));
  // R5: an address cycle captures the bus byte
  assert_addr_latch_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.parAddr |=> addrReg == $past(cfgBus));
endmodule

// File: rtl/cfg_port_top.sv
module cfg_port_top
  import cfg_port_pkg::*;
#(
  parameter int NUM_CH      = 3,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int GAIN_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              parMode,
  input  logic              sharePinA,
  input  logic              sharePinB,
  input  logic              sharePinC,
  input  logic [DATA_W-1:0] cfgBus,
  output logic [DATA_W-1:0] sliceData,
  output logic              sliceOe
);
  cfgStrobes_t strobes;

  cfg_port_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .parMode(parMode),
    .pinA(sharePinA), .pinB(sharePinB), .pinC(sharePinC),
    .strobes(strobes)
  );

  cfg_port_regs #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GAIN_W(GAIN_W),
    .CTRL_ADDR(0), .GAIN_BASE(1), .OFFLO_BASE(1 + NUM_CH), .OFFHI_BASE(1 + 2 * NUM_CH)
  ) u_regs (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cfgBus(cfgBus), .sliceData(sliceData)
  );

  assign sliceOe = strobes.readEn;

  // R7: the slice is driven only in parallel mode
  assert_oe_mode_R7: assert property (@(posedge clk) disable iff (!rstN)
    sliceOe |-> parMode);
  // R7: an undriven slice carries zero
  assert_idle_slice_R7: assert property (@(posedge clk) disable iff (!rstN)
    !sliceOe |-> sliceData == '0);
endmodule

// File: tb/cfg_port_top_bench.sv
module cfg_port_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SEED = 1234;

  logic clk = 0, rstN = 0, parMode = 0;
  logic pinA = 0, pinB = 0, pinC = 1;
  logic [7:0] cfgBus = 0;
  logic [7:0] sliceData;
  logic sliceOe;
  int total = 0, bad = 0;
  logic [7:0] mdl [16];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_port_top u_cfg_port_top (
    .clk(clk), .rstN(rstN), .parMode(parMode),
    .sharePinA(pinA), .sharePinB(pinB), .sharePinC(pinC),
    .cfgBus(cfgBus), .sliceData(sliceData), .sliceOe(sliceOe)
  );

  // Stored value for a write, following the map (R8, R9).
  function automatic logic [7:0] storedVal(input logic [7:0] a, input logic [7:0] d);
    if (a == 0) return d;
    if (a >= 1 && a <= 3) return {3'b000, d[4:0]};
    if (a >= 4 && a <= 6) return d;
    if (a >= 7 && a <= 9) return {7'd0, d[0]};
    return 8'h00;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic step();
    repeat (4) @(negedge clk);
  endtask

  task automatic setMode(input logic m);
    if (parMode != m) begin parMode = m; step(); end
  endtask

  task automatic serWord(input logic [7:0] a, input logic [7:0] d, input int nbits);
    logic [23:0] w;
    setMode(0);
    w = {a, d, 8'h00};
    pinC = 0; step();
    for (int i = 0; i < nbits; i++) begin
      pinA = w[23 - (i % 24)]; step();
      pinB = 1; step();
      pinB = 0; step();
    end
    pinC = 1; step(); step();
    pinA = 0;
  endtask

  task automatic parAddrCycle(input logic [7:0] a);
    setMode(1);
    pinA = 0; pinB = 0; cfgBus = a; step();
    pinC = 0; step(); pinC = 1; step();
  endtask

  task automatic parWriteCycle(input logic [7:0] a, input logic [7:0] d);
    parAddrCycle(a);
    pinA = 1; pinB = 0; cfgBus = d; step();
    pinC = 0; step(); pinC = 1; step();
    pinA = 0;
  endtask

  task automatic readCheck(input logic [7:0] a, input string tag);
    parAddrCycle(a);
    pinB = 1; step();
    check(sliceOe === 1'b1, {tag, " R7 oe"}, {7'd0, sliceOe}, 8'h01);
    check(sliceData === mdl[a[3:0]], tag, sliceData, mdl[a[3:0]]);
    pinB = 0; step();
    check(sliceOe === 1'b0 && sliceData === 8'h00, "R7 release", sliceData, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog R1 actual=00 expected=01");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int sd;
    sd = SEED;
    void'($urandom(sd));
    for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
    repeat (3) @(negedge clk);
    check(sliceOe === 1'b0 && sliceData === 8'h00, "R1 reset outputs", sliceData, 8'h00);
    rstN = 1; step();
    check(sliceOe === 1'b0, "R1 oe after reset", {7'd0, sliceOe}, 8'h00);
    for (int a = 0; a < 16; a++) readCheck(8'(a), "R1 R9 reset readback");

    // Directed serial cases
    serWord(8'h00, 8'hA5, 16); mdl[0] = 8'hA5;
    readCheck(8'h00, "R3 serial write ctrl");
    serWord(8'h02, 8'hFF, 16); mdl[2] = storedVal(8'h02, 8'hFF);
    readCheck(8'h02, "R8 gain masking");
    serWord(8'h00, 8'h00, 15);
    readCheck(8'h00, "R4 short word ignored");
    serWord(8'h00, 8'h00, 17);
    readCheck(8'h00, "R4 long word ignored");
    // R2: readback pin held high in serial mode drives nothing
    setMode(0); pinB = 0; pinC = 0; step();
    pinC = 1; pinB = 1; step();
    check(sliceOe === 1'b0 && sliceData === 8'h00, "R2 no readback in serial mode", sliceData, 8'h00);
    pinB = 0; step();
    readCheck(8'h00, "R2 ctrl kept");

    // Directed parallel cases
    parWriteCycle(8'h08, 8'hFF); mdl[8] = storedVal(8'h08, 8'hFF);
    readCheck(8'h08, "R8 sign bit only");
    parWriteCycle(8'h05, 8'h3C); mdl[5] = 8'h3C;
    readCheck(8'h05, "R6 parallel write offset");
    parWriteCycle(8'h0C, 8'h77);
    readCheck(8'h0C, "R9 unmapped write");
    readCheck(8'h05, "R5 address relatch");

    // Random traffic
    for (int n = 0; n < 40; n++) begin
      logic [7:0] a, d;
      a = 8'($urandom % 16);
      d = 8'($urandom);
      if ($urandom % 2) serWord(a, d, 16);
      else parWriteCycle(a, d);
      mdl[a[3:0]] = (storedVal(a, d) == 8'h00 && a > 9) ? mdl[a[3:0]] : storedVal(a, d);
      readCheck(8'($urandom % 16), "R3 R6 R8 random readback");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule